// File: doc/BRIEF.md
# 4x4 Forward Walsh-Hadamard Transform

This block takes a 4x4 block of signed 16-bit samples, one row of four samples per transfer, and produces the 16 coefficients of a two-pass forward Walsh-Hadamard transform. The first pass runs as each row arrives. It applies a saturating pairwise butterfly and scales the result by four. The first coefficient of each row gets an extra +1 whenever the row's even-pair sum is nonzero. The block stores the four row results.

Once the fourth row is in, the block stops accepting input. It then streams the coefficients out one per transfer, in raster order. Each coefficient comes from a vertical butterfly over one column of the stored row results. A rounding step follows: add one for negative values, add three, then shift right arithmetically by three. The result is truncated to 16 bits.

A producer feeds rows with a valid/ready handshake. A consumer drains the coefficients with a second valid/ready handshake and uses the last flag to find block boundaries.

Top module: `wsh4x4_fwd`

## Requirements
- R1: For a row with samples x0..x3 (x_j on in_row bits [16j+15:16j]), the first pass forms a=x0+x2, d=x1+x3, b=x0-x2 and c=x1-x3. Each of these saturates to the range -32768..32767.
- R2: Row result 0 is (a+d)*4, plus 1 when a is nonzero.
- R3: Row results 1, 2 and 3 are (b+c)*4, (b-c)*4 and (a-d)*4, with no nonzero correction, even when a is zero.
- R4: For column k, let Q0..Q3 be the k-th results of input rows 0..3. The second pass forms p=Q0+Q2, q=Q0-Q2, s=Q1+Q3 and t=Q1-Q3. The four outputs are p+s, q+t, q-t and p-s, placed at output rows 0, 1, 2 and 3. Output index i = row*4 + k.
- R5: Each second-pass value v is finalised as (v + (v<0 ? 1 : 0) + 3) shifted right arithmetically by 3. The output is the low 16 bits of that result.
- R6: Second-pass arithmetic carries enough width that full-scale inputs give exactly the R5 result truncated to 16 bits, with no internal wrap.
- R7: A row is taken only on a cycle with in_valid and in_ready both high, and in_ready is high while collecting. After the fourth row, in_ready stays low until coefficient 15 has been accepted, and then returns high.
- R8: out_valid rises on the cycle after the fourth row is taken. The coefficients are delivered in index order 0 to 15, one per cycle with out_valid and out_ready high. out_last is high only with index 15, and out_valid is low once index 15 has been taken.
- R9: While out_valid is high and out_ready is low, out_data and out_last hold their values.
- R10: A synchronous active-high reset discards any partially collected rows or pending coefficients. After reset, in_ready is high, out_valid is low, and the next row taken is row 0 of a new block.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | A row is presented on in_row |
| in_ready | output | 1 | Block is collecting rows |
| in_row | input | 64 | Four signed samples, x_j at bits [16j+15:16j] |
| out_valid | output | 1 | A coefficient is presented on out_data |
| out_ready | input | 1 | Consumer takes the coefficient this cycle |
| out_data | output | 16 | Signed coefficient at the current index |
| out_last | output | 1 | Current coefficient is index 15 |

## Verification
The hardest cases to reach from the ports are those that exercise the widest internal paths. These are first-pass saturation, and second-pass values large enough that a narrow accumulator would wrap before the shift. The stimulus reaches them with blocks of all-maximum and all-minimum samples, and with rows that pit the maximum against the minimum in a subtraction. A second hard case is reset arriving mid-block. The bench asserts reset after two rows have been taken, and again after one coefficient has been drained. It then confirms that the following block lines up from row 0. Throughout, the consumer stalls on a fixed pattern, so the hold behaviour is observed at many indices, including the last.

// File: rtl/wsh_pkg.sv
package wsh_pkg;
    localparam int SAMPLE_W = 16;
    localparam int BLK_N    = 4;

    typedef enum logic {
        PH_LOAD = 1'b0,
        PH_EMIT = 1'b1
    } phase_e;
endpackage

// File: rtl/wsh_row_stage.sv
module wsh_row_stage #(
    parameter  int SW = wsh_pkg::SAMPLE_W,
    localparam int RW = SW + 3
) (
    input  logic [3:0][SW-1:0] x,
    output logic [3:0][RW-1:0] r
);
    localparam logic signed [SW:0] HI = {2'b00, {(SW-1){1'b1}}};
    localparam logic signed [SW:0] LO = {2'b11, {(SW-1){1'b0}}};

    function automatic logic signed [SW:0] ext(input logic [SW-1:0] v);
        return {v[SW-1], v};
    endfunction

    function automatic logic signed [SW-1:0] clip(input logic signed [SW:0] s);
        if (s > HI)      return HI[SW-1:0];
        else if (s < LO) return LO[SW-1:0];
        else             return s[SW-1:0];
    endfunction

    logic signed [SW-1:0] ev_sum, od_sum, ev_dif, od_dif;
    logic signed [RW-1:0] w_es, w_os, w_ed, w_od;

    always_comb begin
        ev_sum = clip(ext(x[0]) + ext(x[2]));
        od_sum = clip(ext(x[1]) + ext(x[3]));
        ev_dif = clip(ext(x[0]) - ext(x[2]));
        od_dif = clip(ext(x[1]) - ext(x[3]));
        w_es   = RW'(ev_sum);
        w_os   = RW'(od_sum);
        w_ed   = RW'(ev_dif);
        w_od   = RW'(od_dif);
        r[0]   = RW'(((w_es + w_os) <<< 2) + RW'(ev_sum != '0));
        r[1]   = RW'((w_ed + w_od) <<< 2);
        r[2]   = RW'((w_ed - w_od) <<< 2);
        r[3]   = RW'((w_es - w_os) <<< 2);
    end
endmodule

// File: rtl/wsh_col_stage.sv
module wsh_col_stage #(
    parameter  int SW = wsh_pkg::SAMPLE_W,
    localparam int RW = SW + 3,
    localparam int CW = SW + 6
) (
    input  logic [3:0][RW-1:0] q,
    output logic [3:0][SW-1:0] y
);
    logic signed [CW-1:0] e [4];
    logic signed [CW-1:0] v [4];
    logic signed [CW-1:0] p, m, s, t;

    always_comb begin
        for (int j = 0; j < 4; j++) e[j] = CW'($signed(q[j]));
        p    = e[0] + e[2];
        m    = e[0] - e[2];
        s    = e[1] + e[3];
        t    = e[1] - e[3];
        v[0] = p + s;
        v[1] = m + t;
        v[2] = m - t;
        v[3] = p - s;
        for (int j = 0; j < 4; j++)
            y[j] = SW'($signed(v[j] + {{(CW-1){1'b0}}, v[j][CW-1]} + CW'(3)) >>> 3);
    end
endmodule

// File: rtl/wsh4x4_fwd.sv
module wsh4x4_fwd
    import wsh_pkg::*;
#(
    parameter int SW = SAMPLE_W
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  in_valid,
    output logic                  in_ready,
    input  logic [BLK_N*SW-1:0]   in_row,
    output logic                  out_valid,
    input  logic                  out_ready,
    output logic [SW-1:0]         out_data,
    output logic                  out_last
);
    localparam int RW  = SW + 3;
    localparam int CNW = $clog2(BLK_N);
    localparam int IXW = $clog2(BLK_N * BLK_N);

    typedef struct packed {
        phase_e                          phase;
        logic [CNW-1:0]                  rcnt;
        logic [IXW-1:0]                  idx;
        logic [BLK_N-1:0][BLK_N-1:0][RW-1:0] rows;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic [BLK_N-1:0][RW-1:0]            row_res;
    logic [BLK_N-1:0][BLK_N-1:0][SW-1:0] col_res;

    wsh_row_stage #(.SW(SW)) u_row (
        .x (in_row),
        .r (row_res)
    );

    for (genvar k = 0; k < BLK_N; k++) begin : g_col
        logic [BLK_N-1:0][RW-1:0] cv;
        logic [BLK_N-1:0][SW-1:0] cy;
        for (genvar j = 0; j < BLK_N; j++) begin : g_tap
            assign cv[j] = ctl_q.rows[j][k];
        end
        wsh_col_stage #(.SW(SW)) u_col (
            .q (cv),
            .y (cy)
        );
        assign col_res[k] = cy;
    end

    assign in_ready  = (ctl_q.phase == PH_LOAD);
    assign out_valid = (ctl_q.phase == PH_EMIT);
    assign out_last  = out_valid && (ctl_q.idx == IXW'(BLK_N * BLK_N - 1));
    assign out_data  = col_res[ctl_q.idx[CNW-1:0]][ctl_q.idx[IXW-1:CNW]];

    always_comb begin
        ctl_d = ctl_q;
        case (ctl_q.phase)
            PH_LOAD: begin
                if (in_valid) begin
                    ctl_d.rows[ctl_q.rcnt] = row_res;
                    ctl_d.rcnt             = CNW'(ctl_q.rcnt + 1'b1);
                    if (ctl_q.rcnt == CNW'(BLK_N - 1)) begin
                        ctl_d.phase = PH_EMIT;
                        ctl_d.idx   = '0;
                    end
                end
            end
            default: begin
                if (out_ready) begin
                    ctl_d.idx = IXW'(ctl_q.idx + 1'b1);
                    if (ctl_q.idx == IXW'(BLK_N * BLK_N - 1)) begin
                        ctl_d.phase = PH_LOAD;
                        ctl_d.rcnt  = '0;
                    end
                end
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) ctl_q <= '0;
        else     ctl_q <= ctl_d;
    end

    AST_OUT_HOLD: assert property (@(posedge clk) disable iff (rst)
        out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_last)); // R9

    AST_LAST_RELOAD: assert property (@(posedge clk) disable iff (rst)
        out_valid && out_ready && out_last |=> in_ready && !out_valid); // R7

    AST_EMIT_START: assert property (@(posedge clk) disable iff (rst)
        $rose(out_valid) |-> !out_last && $past(in_valid && in_ready)); // R8

    AST_EMIT_ADVANCE: assert property (@(posedge clk) disable iff (rst)
        out_valid && out_ready && !out_last |=> out_valid && !in_ready); // R8

    AST_IDLE_WAIT: assert property (@(posedge clk) disable iff (rst)
        in_ready && !in_valid |=> in_ready && !out_valid); // R7
endmodule

// File: tb/wsh4x4_fwd_test.sv
`timescale 1ns/1ps
module wsh4x4_fwd_test;
    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         in_valid = 1'b0;
    logic         out_ready = 1'b0;
    logic [63:0]  in_row = '0;
    logic         in_ready, out_valid, out_last;
    logic [15:0]  out_data;

    int n_cmp = 0;
    int n_bad = 0;

    always #4 clk = ~clk;

    wsh4x4_fwd uut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
        .in_row(in_row), .out_valid(out_valid), .out_ready(out_ready),
        .out_data(out_data), .out_last(out_last)
    );

    typedef struct packed {
        logic [255:0] blk;
        logic [255:0] exp;
    } vec_t;

    localparam vec_t TAB [4] = '{
        '{blk: 256'h0,           exp: 256'h0},
        '{blk: {16{16'h0001}},   exp: 256'd8},
        '{blk: 256'hFF9C,        exp: {16{16'hFFCE}}},
        '{blk: 256'h64,          exp: {16{16'h0032}}}
    };

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic int sat16(input int v);
        if (v > 32767)  return 32767;
        if (v < -32768) return -32768;
        return v;
    endfunction

    function automatic logic [255:0] model(input logic [255:0] blk);
        int rr [4][4];
        int x [4];
        int a, b, c, d, v;
        int vv [4];
        logic [255:0] o;
        o = '0;
        for (int r = 0; r < 4; r++) begin
            for (int j = 0; j < 4; j++) x[j] = int'($signed(blk[r*64 + j*16 +: 16]));
            a = sat16(x[0] + x[2]);
            d = sat16(x[1] + x[3]);
            b = sat16(x[0] - x[2]);
            c = sat16(x[1] - x[3]);
            rr[r][0] = (a + d) * 4 + ((a != 0) ? 1 : 0);
            rr[r][1] = (b + c) * 4;
            rr[r][2] = (b - c) * 4;
            rr[r][3] = (a - d) * 4;
        end
        for (int k = 0; k < 4; k++) begin
            a = rr[0][k] + rr[2][k];
            b = rr[0][k] - rr[2][k];
            d = rr[1][k] + rr[3][k];
            c = rr[1][k] - rr[3][k];
            vv[0] = a + d;
            vv[1] = b + c;
            vv[2] = b - c;
            vv[3] = a - d;
            for (int row = 0; row < 4; row++) begin
                v = vv[row] + ((vv[row] < 0) ? 1 : 0) + 3;
                v = v >>> 3;
                o[(row*4 + k)*16 +: 16] = v[15:0];
            end
        end
        return o;
    endfunction

    task automatic send_rows(input logic [255:0] blk, input int gap);
        for (int r = 0; r < 4; r++) begin
            for (int g = 0; g < gap; g++) begin
                @(negedge clk);
                in_valid = 1'b0;
            end
            @(negedge clk);
            check("R7 in_ready high while collecting", in_ready, 1);
            in_valid = 1'b1;
            in_row   = blk[r*64 +: 64];
        end
        @(negedge clk);
        in_valid = 1'b0;
        check("R7 in_ready low after fourth row", in_ready, 0);
        check("R8 out_valid after fourth row", out_valid, 1);
    endtask

    task automatic take_outputs(input logic [255:0] exp, input int stall, input string tag);
        int got = 0;
        int cyc = 0;
        logic hold = 1'b0;
        logic [15:0] hv = '0;
        while (got < 16) begin
            @(negedge clk);
            check("R7 in_ready low while emitting", in_ready, 0);
            check("R8 out_valid during emission", out_valid, 1);
            if (hold) check("R9 data held under stall", out_data, hv);
            if (stall != 0 && (cyc % 3) == 1) begin
                out_ready = 1'b0;
                hold      = 1'b1;
                hv        = out_data;
            end else begin
                out_ready = 1'b1;
                hold      = 1'b0;
                check({tag, " R4 R5 coefficient"}, out_data, exp[got*16 +: 16]);
                check("R8 out_last flag", out_last, (got == 15));
                got++;
            end
            cyc++;
        end
        @(negedge clk);
        out_ready = 1'b0;
        check("R7 in_ready back after index 15", in_ready, 1);
        check("R8 out_valid low after index 15", out_valid, 0);
    endtask

    task automatic run_block(input logic [255:0] blk, input logic [255:0] exp,
                             input int stall, input int gap, input string tag);
        send_rows(blk, gap);
        take_outputs(exp, stall, tag);
    endtask

    initial begin
        #(8 * 150000);
        n_bad++;
        $display("FAIL watchdog expired");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        logic [255:0] blk;
        logic [31:0]  seed;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R10 in_ready after reset", in_ready, 1);
        check("R10 out_valid after reset", out_valid, 0);

        // hand-computed table: zero block, ones (R2 +1), -100 (R5 negative), +100
        for (int i = 0; i < 4; i++)
            run_block(TAB[i].blk, TAB[i].exp, i % 2, 0, "R2 R5 table");

        // R1 R6: saturation and full-scale blocks
        blk = {16{16'h7FFF}};
        run_block(blk, model(blk), 0, 0, "R1 R6 all max");
        blk = {16{16'h8000}};
        run_block(blk, model(blk), 1, 0, "R1 R6 all min");
        blk = {4{64'h8000_8000_7FFF_7FFF}};
        run_block(blk, model(blk), 1, 1, "R1 R6 saturating difference");
        // R3: a zero even-pair sum with nonzero differences
        blk = {4{64'hFFFD_FFFB_0003_0005}};
        run_block(blk, model(blk), 0, 0, "R3 no correction");

        // pseudo-random blocks with gaps and stalls
        seed = 32'h1234_5678;
        for (int n = 0; n < 6; n++) begin
            for (int w = 0; w < 8; w++) begin
                seed = seed * 32'd1664525 + 32'd1013904223;
                blk[w*32 +: 32] = seed;
            end
            run_block(blk, model(blk), n % 2, n % 3, "R4 R7 R9 mixed");
        end

        // R10: reset after two rows, next block must start at row 0
        @(negedge clk);
        in_valid = 1'b1;
        in_row   = 64'h7FFF_7FFF_7FFF_7FFF;
        @(negedge clk);
        in_row   = 64'h8000_1234_7FFF_0042;
        @(negedge clk);
        in_valid = 1'b0;
        rst      = 1'b1;
        @(negedge clk);
        rst      = 1'b0;
        run_block({16{16'h0001}}, 256'd8, 0, 0, "R10 partial rows discarded");

        // R10: reset during emission
        send_rows({16{16'h0001}}, 0);
        @(negedge clk);
        out_ready = 1'b1;
        @(negedge clk);
        out_ready = 1'b0;
        rst       = 1'b1;
        @(negedge clk);
        rst       = 1'b0;
        check("R10 out_valid cleared mid-emission", out_valid, 0);
        check("R10 in_ready after mid-emission reset", in_ready, 1);
        run_block(256'h64, {16{16'h0032}}, 1, 0, "R10 block after reset");

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule